// File: doc/BRIEF.md
# Banked Logical Memory Reader

This block lets a fixed set of small physical memory banks be read as if they were a few larger logical memories. The banks hold the caller's data and the block keeps none of it. A request names a logical memory `mem_idx` and an element `elem_idx` and is started with a single-cycle `go`. The block lays the banks end to end in order and works out which bank and which word hold the element. It issues exactly one synchronous read and loads the returned word into a holding register. It then pulses `done`.

The bank read port (one-hot enables, a shared word address and the concatenated read data) comes out at the top level, so storage outside the block answers the reads. The shape of the logical view is fixed when the block is built. With six banks of four words, a logical count of 2 gives two memories of twelve words each. A logical count of 3 gives three memories of eight words each. A request outside the legal ranges completes at once with an error flag and touches no bank.

Top module: `bank_view`

## Requirements
- R1: The logical depth equals NUM_BANKS*BANK_DEPTH/LOG_COUNT. With the defaults (6 banks, 4 words, 32 bits), LOG_COUNT=2 gives depth 12 and LOG_COUNT=3 gives depth 8. Logical element (1,0) lies in bank 3 for depth 12 and in bank 2 for depth 8.
- R2: For a legal request, the flat position is mem_idx*depth+elem_idx. The bank read is bank flat/BANK_DEPTH at word flat%BANK_DEPTH: bank k is enabled through `bank_rd_en[k]`, and its data arrives on `bank_rdata[k*DATA_W +: DATA_W]`. `result` is set to that word.
- R3: The cycle after a legal `go` is sampled, exactly one bank enable is high for one cycle. `result` is loaded and `done` is high for one cycle two cycles after that enable cycle, so `done` comes three clock edges after `go`.
- R4: `result` keeps its value from one legal completion to the next and changes only in a `done` cycle.
- R5: A request with mem_idx >= LOG_COUNT or elem_idx >= depth raises `done` and `err` together one edge after `go`. It asserts no bank enable and leaves `result` unchanged.
- R6: `go` and changes on the index inputs are ignored while a read is in progress (the two cycles after a legal `go` is accepted).
- R7: At most one bit of `bank_rd_en` is high in any cycle.
- R8: `err` is high only in the `done` cycle of a rejected request.
- R9: While reset is asserted, `done`, `err`, `result` and `bank_rd_en` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Request strobe, sampled only while idle |
| mem_idx | input | IDX_W | Logical memory index |
| elem_idx | input | IDX_W | Element index inside the logical memory |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request was out of range, valid with done |
| result | output | DATA_W | Holding register with the last word read |
| bank_rd_en | output | NUM_BANKS | One-hot read enables, one per bank |
| bank_addr | output | ADDR_W | Word address shared by all banks |
| bank_rdata | input | NUM_BANKS*DATA_W | Concatenated bank read data, one cycle after enable |

## Verification
A wrong bank select or word offset returns a different bank's data. Every bank word holds a distinct value, so the error shows in `result` in the same `done` cycle, three edges after `go`. A stuck or skipped state appears at once as a wrong `done` latency, a missing or second enable cycle, or an extra `done` pulse. A rejected request that leaks through shows in the same cycle as an enable pulse or as a changed held result.

// File: rtl/bank_view.sv
module bank_view #(
  parameter int NUM_BANKS  = 6,
  parameter int BANK_DEPTH = 4,
  parameter int DATA_W     = 32,
  parameter int LOG_COUNT  = 2,
  parameter int IDX_W      = 8,
  localparam int ADDR_W    = $clog2(BANK_DEPTH > 1 ? BANK_DEPTH : 2)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        go,
  input  logic [IDX_W-1:0]            mem_idx,
  input  logic [IDX_W-1:0]            elem_idx,
  output logic                        done,
  output logic                        err,
  output logic [DATA_W-1:0]           result,
  output logic [NUM_BANKS-1:0]        bank_rd_en,
  output logic [ADDR_W-1:0]           bank_addr,
  input  logic [NUM_BANKS*DATA_W-1:0] bank_rdata
);
  localparam int LOG_DEPTH = NUM_BANKS * BANK_DEPTH / LOG_COUNT;
  localparam int SEL_W     = $clog2(NUM_BANKS > 1 ? NUM_BANKS : 2);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_CAP} st_t;

  st_t               state;
  logic [SEL_W-1:0]  sel_q, sel_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              legal;
  int                flat;

  always_comb begin
    legal  = (int'(mem_idx) < LOG_COUNT) && (int'(elem_idx) < LOG_DEPTH);
    flat   = int'(mem_idx) * LOG_DEPTH + int'(elem_idx);
    sel_d  = SEL_W'(flat / BANK_DEPTH);
    addr_d = ADDR_W'(flat % BANK_DEPTH);
  end

  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_en
    assign bank_rd_en[k] = (state == S_RD) && (sel_q == SEL_W'(k));
  end

  assign bank_addr = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      done   <= 1'b0;
      err    <= 1'b0;
      result <= '0;
      sel_q  <= '0;
      addr_q <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (state)
        S_IDLE: if (go) begin
          if (legal) begin
            sel_q  <= sel_d;
            addr_q <= addr_d;
            state  <= S_RD;
          end else begin
            done <= 1'b1;
            err  <= 1'b1;
          end
        end
        S_RD:  state <= S_CAP;
        S_CAP: begin
          result <= bank_rdata[int'(sel_q)*DATA_W +: DATA_W];
          done   <= 1'b1;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bank_view_chk.sv
module bank_view_chk #(
  parameter int NUM_BANKS = 6,
  parameter int DATA_W    = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 done,
  input logic                 err,
  input logic [DATA_W-1:0]    result,
  input logic [NUM_BANKS-1:0] bank_rd_en
);
  // R7
  one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_rd_en));

  // R3
  en_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|bank_rd_en) |=> (!done && bank_rd_en == '0) ##1 (done && !err));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> done);

  // R5
  err_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> ($stable(result) && bank_rd_en == '0));

  // R8
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
endmodule

bind bank_view bank_view_chk #(.NUM_BANKS(NUM_BANKS), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .done(done), .err(err),
  .result(result), .bank_rd_en(bank_rd_en));

// File: tb/bank_view_tb_top.sv
module bank_view_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic go2 = 0, go3 = 0;
  logic [7:0] i2 = 0, j2 = 0, i3 = 0, j3 = 0;
  logic done2, done3, err2, err3;
  logic [31:0] res2, res3;
  logic [5:0] en2, en3;
  logic [1:0] addr2, addr3;
  logic [191:0] rd2 = '0, rd3 = '0;

  bank_view #(.LOG_COUNT(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .go(go2), .mem_idx(i2), .elem_idx(j2),
    .done(done2), .err(err2), .result(res2), .bank_rd_en(en2),
    .bank_addr(addr2), .bank_rdata(rd2));

  bank_view #(.LOG_COUNT(3)) dut3_i (
    .clk(clk), .rst_n(rst_n), .go(go3), .mem_idx(i3), .elem_idx(j3),
    .done(done3), .err(err3), .result(res3), .bank_rd_en(en3),
    .bank_addr(addr3), .bank_rdata(rd3));

  function automatic logic [31:0] bank_val(int b, int w);
    return 32'hC0DE_0000 + 32'(b * 16 + w);
  endfunction

  always_ff @(posedge clk)
    for (int b = 0; b < 6; b++) begin
      if (en2[b]) rd2[b*32 +: 32] <= bank_val(b, int'(addr2));
      if (en3[b]) rd3[b*32 +: 32] <= bank_val(b, int'(addr3));
    end

  int total = 0, bad = 0;
  int lat, en_cycles, en_bank, en_addr, multi;
  logic [31:0] got_res, last2 = 0, last3 = 0;
  logic got_err;

  function automatic int depth(bit g3);
    return g3 ? 8 : 12;
  endfunction
  function automatic bit is_legal(bit g3, int i, int j);
    return i < (g3 ? 3 : 2) && j < depth(g3);
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(bit g3, logic g, int i, int j);
    if (g3) begin go3 = g; i3 = 8'(i); j3 = 8'(j); end
    else    begin go2 = g; i2 = 8'(i); j2 = 8'(j); end
  endtask

  task automatic req(bit g3, int i, int j, int hold, int alt_i, int alt_j);
    logic [5:0] en;
    logic dn;
    @(negedge clk);
    drive(g3, 1'b1, i, j);
    lat = 0; en_cycles = 0; en_bank = -1; en_addr = -1; multi = 0;
    for (int c = 1; c <= 12; c++) begin
      @(negedge clk);
      if (c == 1) drive(g3, 1'b1, alt_i, alt_j);
      if (c >= hold) drive(g3, 1'b0, alt_i, alt_j);
      en = g3 ? en3 : en2;
      dn = g3 ? done3 : done2;
      if (en != 0) begin
        en_cycles++;
        if ($countones(en) > 1) multi = 1;
        for (int b = 0; b < 6; b++) if (en[b]) en_bank = b;
        en_addr = int'(g3 ? addr3 : addr2);
      end
      if (dn) begin
        lat = c;
        got_res = g3 ? res3 : res2;
        got_err = g3 ? err3 : err2;
        break;
      end
    end
  endtask

  task automatic legal_req(bit g3, int i, int j, string tag);
    int f;
    logic [31:0] exp;
    f = i * depth(g3) + j;
    exp = bank_val(f / 4, f % 4);
    req(g3, i, j, 1, i, j);
    chk(got_res == exp, tag, "result word", got_res, exp);
    chk(en_bank == f / 4 && en_addr == f % 4, "R2", "bank/word", 32'(en_bank*4+en_addr), 32'(f));
    chk(lat == 3 && en_cycles == 1, "R3", "latency/enables", 32'(lat*16+en_cycles), 32'h31);
    chk(multi == 0, "R7", "single enable", 32'(multi), 0);
    chk(got_err == 0, "R8", "err on legal", 32'(got_err), 0);
    @(negedge clk);
    chk((g3 ? done3 : done2) == 0, "R3", "done one cycle", 32'(g3 ? done3 : done2), 0);
    if (g3) last3 = exp; else last2 = exp;
  endtask

  task automatic bad_req(bit g3, int i, int j);
    logic [31:0] prev;
    prev = g3 ? last3 : last2;
    req(g3, i, j, 1, i, j);
    chk(lat == 1 && got_err == 1, "R5", "reject timing/err", 32'(lat*16+got_err), 32'h11);
    chk(en_cycles == 0, "R5", "no enable", 32'(en_cycles), 0);
    chk(got_res == prev, "R5", "result unchanged", got_res, prev);
    @(negedge clk);
    chk((g3 ? err3 : err2) == 0, "R8", "err cleared", 32'(g3 ? err3 : err2), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R9
    chk(done2 == 0 && err2 == 0 && res2 == 0 && en2 == 0, "R9", "reset g2", res2, 0);
    chk(done3 == 0 && err3 == 0 && res3 == 0 && en3 == 0, "R9", "reset g3", res3, 0);
    rst_n = 1'b1;

    // R1: element (1,0) crosses into bank 3 (depth 12) or bank 2 (depth 8)
    req(1'b0, 1, 0, 1, 1, 0);
    chk(en_bank == 3 && got_res == bank_val(3, 0), "R1", "depth12 (1,0)", got_res, bank_val(3, 0));
    last2 = got_res;
    req(1'b1, 1, 0, 1, 1, 0);
    chk(en_bank == 2 && got_res == bank_val(2, 0), "R1", "depth8 (1,0)", got_res, bank_val(2, 0));
    last3 = got_res;

    for (int i = 0; i < 2; i++) for (int j = 0; j < 12; j++) legal_req(1'b0, i, j, "R2");
    for (int i = 0; i < 3; i++) for (int j = 0; j < 8; j++)  legal_req(1'b1, i, j, "R2");

    repeat (5) @(negedge clk);
    // R4
    chk(res2 == last2, "R4", "held g2", res2, last2);
    chk(res3 == last3, "R4", "held g3", res3, last3);

    bad_req(1'b0, 2, 0);  bad_req(1'b0, 0, 12); bad_req(1'b0, 255, 255);
    bad_req(1'b1, 3, 0);  bad_req(1'b1, 0, 8);  bad_req(1'b1, 2, 200);

    // R6: go held through the read with other indices
    req(1'b0, 0, 1, 3, 1, 11);
    chk(got_res == bank_val(0, 1) && lat == 3 && en_cycles == 1, "R6", "busy ignore g2", got_res, bank_val(0, 1));
    last2 = got_res;
    @(negedge clk);
    chk(done2 == 0 && en2 == 0, "R6", "no second op g2", 32'({done2, en2}), 0);
    req(1'b1, 2, 7, 3, 0, 0);
    chk(got_res == bank_val(5, 3) && lat == 3 && en_cycles == 1, "R6", "busy ignore g3", got_res, bank_val(5, 3));
    last3 = got_res;
    @(negedge clk);
    chk(done3 == 0 && en3 == 0, "R6", "no second op g3", 32'({done3, en3}), 0);

    for (int n = 0; n < 200; n++) begin
      bit g3;
      int i, j;
      g3 = 1'($urandom % 2);
      i = int'($urandom % 4);
      j = int'($urandom % 16);
      if (is_legal(g3, i, j)) legal_req(g3, i, j, "R2");
      else bad_req(g3, i, j);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule